// File: doc/BRIEF.md
# Four-Lane Loopback Self-Test Engine

This block is a built-in self-test engine for a four-lane serial path. Software programs a 16-bit control word to choose one of four test patterns and an 8-bit or 10-bit symbol width. It then enables the engine in one write and starts it in a later write. While the test runs, a pattern generator sends frames of a fixed number of symbols on every lane. The frames return through an internal one-cycle loopback stage. A checker on each lane rebuilds the expected pattern on its own and counts the frames it receives and the symbols that do not match.

Software ends a run by writing the stop bit. The generator finishes the frame it is sending. The stop bit clears itself once every lane has checked that frame. After that, software reads the transmit frame count, the per-lane receive frame counts and the per-lane error counts. A lane passes when its error count is zero and its frame count is nonzero. A loopback-enable output is high while a run or its drain is in progress. An error-injection input flips one bit on a chosen lane, so the error counters themselves can be tested.

The register port is a plain single-cycle port. A write takes effect at the clock edge on which `reg_we` is high. A read returns data combinationally for `reg_addr`. There is no back-pressure: every access completes in its own cycle. The block has no streaming data interface at its edge, so no valid/ready handshake applies.

Top module: `bist_engine`

## Requirements
- R1: After reset the control word reads 0x0000, every counter reads 0 and `loop_en` is low.
- R2: Control word layout. Bits 11:10 hold the pattern type: 0 counting, 1 alternating, 2 walking-one, 3 pseudo-random. Bit 12 is 1 for 10-bit symbols and 0 for 8-bit symbols. Bit 13 is enable, bit 14 is stop and bit 15 is start. Bits 9:0 always read 0. Type and width written while idle read back as written.
- R3: A write with the start bit set starts a run only if enable was already 1 before that write. Otherwise start stays 0 and no frames are sent.
- R4: Starting a run clears the transmit frame count and every per-lane frame and error count.
- R5: `loop_en` is high exactly while start or stop reads 1.
- R6: Writing stop (with enable kept at 1) during a run clears start and sets stop. Stop clears itself only after the current frame has been sent and checked on every lane. After that, each lane's frame count equals the transmit frame count.
- R7: With no injection, every pattern type at both widths completes with zero errors and a nonzero frame count on every lane.
- R8: A one-cycle `inj_req` pulse while symbols are being sent flips bit 0 of that cycle's symbol on lane `inj_lane`. That lane's error count rises by exactly 1 and the other lanes' error counts stay at 0. A pulse while the engine is idle changes no counter.
- R9: All counters saturate at 2^CNT_W-1 and do not wrap.
- R10: Writing a control word with enable 0 aborts at once. Start, stop and enable read 0 and `loop_en` falls on the next cycle.
- R11: Register map: address 0 is the control word and 1 is the transmit frame count. Addresses 2 to 5 are the lane 0 to 3 frame counts and 6 to 9 are the lane 0 to 3 error counts. Any other address reads 0.
- R12: Type and width bits written while start or stop is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| inj_req | input | 1 | Flip bit 0 of this cycle's symbol on the selected lane |
| inj_lane | input | LANE_W | Lane that receives the injected error |
| loop_en | output | 1 | Local loopback enable, high while a run or drain is active |

## Verification
The bench runs every pattern type at both symbol widths. Some runs inject a single error on one lane. A checker that drifted out of step with the generator would report errors on clean runs. A wrong injection path would put the error on the wrong lane or count it more than once. Ending each run with a stop exposes a drain that finishes too early: the lane frame counts would then trail the transmit count. The bench also targets the corner cases:
- a start written in the same write as the first enable, which must be refused;
- configuration writes made during a run, which must be ignored;
- an abort through enable 0;
- injection while idle, which must change nothing;
- a run long enough to saturate the narrowed counters, where a wrapping counter would read a small value.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [1:0] {
    PAT_COUNT = 2'd0,
    PAT_ALT   = 2'd1,
    PAT_WALK  = 2'd2,
    PAT_PRBS  = 2'd3
  } pat_e;

  localparam int CTRL_TYPE_LSB  = 10;
  localparam int CTRL_WIDE_BIT  = 12;
  localparam int CTRL_EN_BIT    = 13;
  localparam int CTRL_STOP_BIT  = 14;
  localparam int CTRL_START_BIT = 15;

  localparam logic [15:0] PAT_SEED = 16'hACE1;

  // Advance the shared pattern state by one symbol.
  function automatic logic [15:0] pat_next(pat_e t, logic [15:0] s);
    if (t == PAT_PRBS) return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    return s + 16'd1;
  endfunction

  // Symbol for one lane; the upper byte is zeroed in 8-bit mode.
  function automatic logic [15:0] pat_word(pat_e t, logic [15:0] s,
                                           logic [3:0] lane, logic wide);
    logic [15:0] w;
    case (t)
      PAT_COUNT: w = s ^ {12'd0, lane};
      PAT_ALT:   w = (s[0] ? 16'h5555 : 16'hAAAA) ^ {8'd0, lane, 4'd0};
      PAT_WALK:  w = 16'h0001 << (s[3:0] + lane);
      default:   w = s ^ {4{lane}};
    endcase
    if (!wide) w[15:8] = 8'd0;
    return w;
  endfunction

endpackage

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [15:0] ctrl_wdata,
  input  logic        at_bnd,
  input  logic        lane_busy,
  output logic [15:0] ctrl_word,
  output pat_e        pat_type,
  output logic        wide,
  output logic        gen_en,
  output logic        clr,
  output logic        loop_en
);

  logic en_q, start_q, stop_q, wide_q;
  pat_e type_q;
  logic busy, stop_done, wr_en;

  assign busy      = start_q | stop_q;
  assign wr_en     = ctrl_wdata[CTRL_EN_BIT];
  assign stop_done = stop_q & at_bnd & ~lane_busy;
  assign clr       = ctrl_we & wr_en & en_q & ~busy & ctrl_wdata[CTRL_START_BIT];
  assign gen_en    = start_q | (stop_q & ~at_bnd);
  assign loop_en   = busy;
  assign pat_type  = type_q;
  assign wide      = wide_q;
  assign ctrl_word = {start_q, stop_q, en_q, wide_q, type_q, 10'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      wide_q  <= 1'b0;
      type_q  <= PAT_COUNT;
    end else if (ctrl_we && !wr_en) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      wide_q  <= ctrl_wdata[CTRL_WIDE_BIT];
      type_q  <= pat_e'(ctrl_wdata[CTRL_TYPE_LSB +: 2]);
    end else if (ctrl_we && busy) begin
      if (ctrl_wdata[CTRL_STOP_BIT] && start_q) begin
        stop_q  <= 1'b1;
        start_q <= 1'b0;
      end else if (stop_done) begin
        stop_q <= 1'b0;
      end
    end else if (ctrl_we) begin
      en_q   <= 1'b1;
      wide_q <= ctrl_wdata[CTRL_WIDE_BIT];
      type_q <= pat_e'(ctrl_wdata[CTRL_TYPE_LSB +: 2]);
      if (ctrl_wdata[CTRL_START_BIT] && en_q) start_q <= 1'b1;
    end else if (stop_done) begin
      stop_q <= 1'b0;
    end
  end

  // R6
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && stop_q));

  // R3
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> $past(en_q));

  // R5
  loop_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> en_q);

  // R6
  stop_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stop_q) && en_q) |-> $past(at_bnd && !lane_busy));

endmodule

// File: rtl/bist_patgen.sv
module bist_patgen
  import bist_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int SYM_W     = 10,
  parameter int FRAME_LEN = 8,
  parameter int CNT_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   gen_en,
  input  pat_e                   pat_type,
  input  logic                   wide,
  output logic                   sym_valid,
  output logic                   sym_last,
  output logic [LANES*SYM_W-1:0] sym_data,
  output logic                   at_bnd,
  output logic [CNT_W-1:0]       tx_cnt
);

  localparam int IDX_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [IDX_W-1:0] idx_q;
  logic [15:0]      state_q;
  logic [CNT_W-1:0] tx_q;

  assign sym_valid = gen_en;
  assign sym_last  = gen_en && (idx_q == LAST_IDX);
  assign at_bnd    = (idx_q == '0);
  assign tx_cnt    = tx_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [15:0] w;
    assign w = pat_word(pat_type, state_q, 4'(i), wide);
    assign sym_data[i*SYM_W +: SYM_W] = w[SYM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      state_q <= PAT_SEED;
      tx_q    <= '0;
    end else if (clr) begin
      idx_q   <= '0;
      state_q <= PAT_SEED;
      tx_q    <= '0;
    end else if (gen_en) begin
      state_q <= pat_next(pat_type, state_q);
      idx_q   <= sym_last ? '0 : idx_q + 1'b1;
      if (sym_last && tx_q != CNT_MAX) tx_q <= tx_q + 1'b1;
    end
  end

  // R9
  tx_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_q == CNT_MAX && !clr) |=> tx_q == CNT_MAX);

endmodule

// File: rtl/bist_loopback.sv
module bist_loopback #(
  parameter int LANES = 4,
  parameter int SYM_W = 10,
  parameter int LANE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_last,
  input  logic [LANES*SYM_W-1:0] in_data,
  input  logic                   inj_req,
  input  logic [LANE_W-1:0]      inj_lane,
  output logic                   out_valid,
  output logic                   out_last,
  output logic [LANES*SYM_W-1:0] out_data,
  output logic                   busy
);

  logic valid_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      valid_q <= in_valid;
      last_q  <= in_last;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic flip;
    logic [SYM_W-1:0] data_q;
    assign flip = inj_req && in_valid && (inj_lane == LANE_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q <= '0;
      else        data_q <= in_data[i*SYM_W +: SYM_W] ^ {{(SYM_W-1){1'b0}}, flip};
    end
    assign out_data[i*SYM_W +: SYM_W] = data_q;
  end

  assign out_valid = valid_q;
  assign out_last  = last_q;
  assign busy      = valid_q;

endmodule

// File: rtl/bist_lane_chk.sv
module bist_lane_chk
  import bist_pkg::*;
#(
  parameter int LANE_ID = 0,
  parameter int SYM_W   = 10,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  pat_e             pat_type,
  input  logic             wide,
  input  logic             rx_valid,
  input  logic             rx_last,
  input  logic [SYM_W-1:0] rx_data,
  output logic [CNT_W-1:0] frm_cnt,
  output logic [CNT_W-1:0] err_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [15:0]      s_q;
  logic [15:0]      exp_w;
  logic             mism;
  logic [CNT_W-1:0] frm_q, err_q;

  assign exp_w   = pat_word(pat_type, s_q, 4'(LANE_ID), wide);
  assign mism    = rx_valid && (rx_data != exp_w[SYM_W-1:0]);
  assign frm_cnt = frm_q;
  assign err_cnt = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q   <= PAT_SEED;
      frm_q <= '0;
      err_q <= '0;
    end else if (clr) begin
      s_q   <= PAT_SEED;
      frm_q <= '0;
      err_q <= '0;
    end else if (rx_valid) begin
      s_q <= pat_next(pat_type, s_q);
      if (mism && err_q != CNT_MAX) err_q <= err_q + 1'b1;
      if (rx_last && frm_q != CNT_MAX) frm_q <= frm_q + 1'b1;
    end
  end

  // R9
  frm_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_q == CNT_MAX && !clr) |=> frm_q == CNT_MAX);

  // R9
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q == CNT_MAX && !clr) |=> err_q == CNT_MAX);

  // R8
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (err_q == $past(err_q) || err_q == $past(err_q) + 1'b1));

endmodule

// File: rtl/bist_engine.sv
module bist_engine
  import bist_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int SYM_W     = 10,
  parameter int FRAME_LEN = 8,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              inj_req,
  input  logic [LANE_W-1:0] inj_lane,
  output logic              loop_en
);

  localparam int FRM_BASE = 2;
  localparam int ERR_BASE = FRM_BASE + LANES;

  logic        ctrl_we;
  logic [15:0] ctrl_word;
  pat_e        pat_type;
  logic        wide, gen_en, clr, at_bnd, lane_busy;
  logic        sym_valid, sym_last, rx_valid, rx_last;
  logic [LANES*SYM_W-1:0] sym_data, rx_data;
  logic [CNT_W-1:0] tx_cnt;
  logic [CNT_W-1:0] frm_cnt [LANES];
  logic [CNT_W-1:0] err_cnt [LANES];

  assign ctrl_we = reg_we && (reg_addr == '0);

  bist_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(reg_wdata),
    .at_bnd(at_bnd), .lane_busy(lane_busy), .ctrl_word(ctrl_word),
    .pat_type(pat_type), .wide(wide), .gen_en(gen_en), .clr(clr),
    .loop_en(loop_en)
  );

  bist_patgen #(.LANES(LANES), .SYM_W(SYM_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .clr(clr), .gen_en(gen_en), .pat_type(pat_type),
    .wide(wide), .sym_valid(sym_valid), .sym_last(sym_last), .sym_data(sym_data),
    .at_bnd(at_bnd), .tx_cnt(tx_cnt)
  );

  bist_loopback #(.LANES(LANES), .SYM_W(SYM_W), .LANE_W(LANE_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .in_valid(sym_valid), .in_last(sym_last),
    .in_data(sym_data), .inj_req(inj_req), .inj_lane(inj_lane),
    .out_valid(rx_valid), .out_last(rx_last), .out_data(rx_data), .busy(lane_busy)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    bist_lane_chk #(.LANE_ID(i), .SYM_W(SYM_W), .CNT_W(CNT_W)) u_chk (
      .clk(clk), .rst_n(rst_n), .clr(clr), .pat_type(pat_type), .wide(wide),
      .rx_valid(rx_valid), .rx_last(rx_last), .rx_data(rx_data[i*SYM_W +: SYM_W]),
      .frm_cnt(frm_cnt[i]), .err_cnt(err_cnt[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0)              reg_rdata = ctrl_word;
    else if (reg_addr == ADDR_W'(1)) reg_rdata = 16'(tx_cnt);
    for (int i = 0; i < LANES; i++) begin
      if (reg_addr == ADDR_W'(FRM_BASE + i)) reg_rdata = 16'(frm_cnt[i]);
      if (reg_addr == ADDR_W'(ERR_BASE + i)) reg_rdata = 16'(err_cnt[i]);
    end
  end

endmodule

// File: tb/bist_engine_tb.sv
module bist_engine_tb;

  localparam int CNT_W = 6;
  localparam int FRAME_LEN = 4;
  localparam logic [15:0] SAT = 16'd63;
  localparam logic [15:0] EN = 16'h2000, STOP = 16'h4000, START = 16'h8000;

  // [15:8] run cycles, [5:4] lane, [3] inject, [2] wide, [1:0] type
  localparam logic [15:0] VEC [8] = '{
    16'h2804, 16'h2401, 16'h342E, 16'h2C07,
    16'h1E08, 16'h303D, 16'h2002, 16'h3C1B
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic inj_req = 1'b0;
  logic [1:0] inj_lane = '0;
  logic loop_en;

  int n_checks = 0;
  int n_err = 0;
  logic [15:0] v, cfg, tx;

  always #2 clk = ~clk;

  bist_engine #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .inj_req(inj_req),
    .inj_lane(inj_lane), .loop_en(loop_en)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic stop_and_wait(input logic [15:0] c);
    wr(4'd0, c | STOP);
    for (int k = 0; k < 64; k++) begin
      rd(4'd0, v);
      if (!v[14]) break;
    end
  endtask

  task automatic pulse_inj(input logic [1:0] l);
    @(negedge clk);
    inj_req = 1'b1; inj_lane = l;
    @(negedge clk);
    inj_req = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, v); check("R1 ctrl", v, 16'h0000);
    rd(4'd1, v); check("R1 tx", v, 16'h0000);
    rd(4'd6, v); check("R1 err0", v, 16'h0000);
    check("R1 loop_en", {15'd0, loop_en}, 16'h0001 & 16'h0000);

    // R3 start in the same write as first enable is refused
    wr(4'd0, EN | START);
    rd(4'd0, v); check("R3 ctrl", v, EN);
    check("R3 loop_en", {15'd0, loop_en}, 16'h0000);
    repeat (20) @(negedge clk);
    rd(4'd1, v); check("R3 tx", v, 16'h0000);

    // R2 field readback, low bits read 0
    wr(4'd0, 16'h3BFF);
    rd(4'd0, v); check("R2 ctrl", v, 16'h3800);

    // R7 R8 R6 R5 vector table
    for (int i = 0; i < 8; i++) begin
      logic [15:0] e;
      e = VEC[i];
      cfg = EN | {3'd0, e[2], e[1:0], 10'd0};
      wr(4'd0, cfg);
      wr(4'd0, cfg | START);
      check("R5 loop_en run", {15'd0, loop_en}, 16'h0001);
      repeat (int'(e[15:8]) / 2) @(negedge clk);
      if (e[3]) pulse_inj(e[5:4]);
      repeat (int'(e[15:8]) / 2) @(negedge clk);
      stop_and_wait(cfg);
      check("R6 ctrl after stop", v, cfg);
      check("R5 loop_en idle", {15'd0, loop_en}, 16'h0000);
      rd(4'd1, tx);
      check("R7 tx nonzero", {15'd0, tx != 16'd0}, 16'h0001);
      for (int l = 0; l < 4; l++) begin
        rd(4'(2 + l), v); check("R6 lane frames", v, tx);
        rd(4'(6 + l), v);
        check("R8 R7 lane errors", v, (e[3] && e[5:4] == 2'(l)) ? 16'd1 : 16'd0);
      end
    end

    // R4 restart clears counters (lane 1 held 1 error)
    cfg = EN | 16'h0C00;
    wr(4'd0, cfg | START);
    rd(4'd7, v); check("R4 err1 cleared", v, 16'h0000);
    rd(4'd1, v); check("R4 tx cleared", v, 16'h0000);
    // R12 config write during run ignored
    wr(4'd0, EN | 16'h1400);
    rd(4'd0, v); check("R12 ctrl", v, cfg | START);
    stop_and_wait(cfg);

    // R8 injection while idle has no effect
    rd(4'd7, v); check("R8 idle before", v, 16'h0000);
    pulse_inj(2'd1);
    repeat (3) @(negedge clk);
    rd(4'd7, v); check("R8 idle after", v, 16'h0000);

    // R10 abort through enable 0
    wr(4'd0, cfg | START);
    repeat (10) @(negedge clk);
    wr(4'd0, 16'h0000);
    rd(4'd0, v); check("R10 ctrl", v, 16'h0000);
    check("R10 loop_en", {15'd0, loop_en}, 16'h0000);

    // R9 saturation
    wr(4'd0, EN);
    wr(4'd0, EN | START);
    repeat (400) @(negedge clk);
    stop_and_wait(EN);
    rd(4'd1, v); check("R9 tx sat", v, SAT);
    rd(4'd5, v); check("R9 frames3 sat", v, SAT);
    rd(4'd9, v); check("R9 err3", v, 16'h0000);

    // R11 unmapped addresses
    rd(4'd10, v); check("R11 addr10", v, 16'h0000);
    rd(4'd15, v); check("R11 addr15", v, 16'h0000);

    finish_run();
  end

endmodule